// File: doc/BRIEF.md
# Multi-Client Synchronous SRAM Arbiter

This block shares one pipelined, zero-bus-turnaround SRAM port among several client modules. Each client has its own request and grant, a read/write select, an address, write data, and a read-data return with a valid strobe. A client raises its request, waits for its grant, and then issues one transaction per clock for as long as it keeps the request high. Each cycle it selects read or write with `cl_rnw`. Dropping the request gives the port back. When no client owns the port, the next owner is chosen round-robin, and the search starts just after the most recent owner.

A client that keeps the port too long while others wait loses its grant. The client must then finish its work and drop its request. Ownership moves on only once that request has fallen. The datapath registers every client-side input once at the boundary and adds fixed pipeline stages. As a result, every client sees the same latency: read data returns six cycles after the command, and a write lands in the device five cycles after the command. Returning read data carries the issuing client's index, so only that client's valid strobe fires.

The controller has three states. `ST_IDLE` means no owner. `ST_OWN` means the owner holds a grant. `ST_REVOKE` means the grant has been withdrawn and the arbiter waits for the owner to let go. The transitions are:
- `grant`: ST_IDLE to ST_OWN.
- `handover`: ST_OWN to ST_OWN with a new owner, when the owner drops its request while others wait.
- `release`: ST_OWN to ST_IDLE.
- `withdraw`: ST_OWN to ST_REVOKE.
- `revoke_pass`: ST_REVOKE to ST_OWN.
- `revoke_idle`: ST_REVOKE to ST_IDLE.

Top module: `sram_port_arbiter`

## Requirements
- R1: With the port idle, a requesting client's grant goes high one clock edge after the request is sampled. A grant is only ever raised for a client whose request was high at that edge.
- R2: While the owner holds its request and no other client requests, its grant stays high indefinitely.
- R3: When the owner's request is sampled low, its grant falls at that edge. If other clients are requesting, the grant moves to the next one in the same edge; otherwise all grants are low.
- R4: The round-robin search starts at the client after the most recent owner and wraps around. After reset, the most recent owner counts as the highest-numbered client, so client 0 wins first.
- R5: If another client has been requesting for `REVOKE_WAIT` consecutive edges while the owner holds its request, the owner's grant falls after the `REVOKE_WAIT`-th such edge. Any edge with no other client requesting restarts that count from zero.
- R6: After a withdrawal, no client is granted while the former owner keeps its request high. The former owner's transactions are still carried out. The grant passes at the edge where that request is sampled low.
- R7: A read (`cl_rnw` = 1) accepted at edge E raises only the issuing client's `cl_rvalid` bit after edge E+6, with the data stored at that address. Every other client's `cl_rdata` keeps its previous value.
- R8: A write (`cl_rnw` = 0) accepted at edge E puts the address with `sram_rnw` low on the device pins after E+1 and the write data on `sram_wdata` after E+3. The device stores it at E+5.
- R9: `sram_rnw` is high in every cycle that does not carry an accepted write. After reset, all grants and read-valid strobes are low.
- R10: A transaction is accepted only at an edge where the client owns the port (granted, or withdrawn but still holding its request) and its request is high. The address and data of non-owners never reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cl_req | input | N_CLIENTS | Per-client access request |
| cl_gnt | output | N_CLIENTS | Per-client grant |
| cl_rnw | input | N_CLIENTS | Per-client select, 1 = read, 0 = write |
| cl_addr | input | N_CLIENTS*ADDR_W | Per-client address, client k at bits k*ADDR_W |
| cl_wdata | input | N_CLIENTS*DATA_W | Per-client write data, client k at bits k*DATA_W |
| cl_rdata | output | N_CLIENTS*DATA_W | Per-client read data, held between returns |
| cl_rvalid | output | N_CLIENTS | Per-client read-data strobe |
| sram_addr | output | ADDR_W | Device address |
| sram_rnw | output | 1 | Device read/write line, low only for a write |
| sram_wdata | output | DATA_W | Device write data, two cycles behind the address |
| sram_rdata | input | DATA_W | Device read data, SRAM_PIPE cycles after the address |

## Verification
The hardest state to reach is withdrawal. It needs an owner that keeps its request high while a second client requests for exactly `REVOKE_WAIT` edges. The owner must then keep its request high for a while after losing its grant, and its commands in that window still have to come back correctly. The bench scripts this with a small wait limit. It checks the grant on every edge of the count and repeats the run with the waiting client dropping out for one edge to show the count restarts. A per-cycle scoreboard predicts the pins and the read returns from every accepted command. While the owner streams writes and reads, the other clients drive conflicting writes at the same time.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OWN    = 2'd1,
        ST_REVOKE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/sarb_rr_pick.sv
module sarb_rr_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             hit,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        hit = 1'b0;
        win = last;
        for (int k = 1; k <= N; k++) begin
            if (!hit && req[(int'(last) + k) % N]) begin
                hit = 1'b1;
                win = IDX_W'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/sarb_ctrl.sv
module sarb_ctrl
    import sarb_pkg::*;
#(
    parameter int N           = 3,
    parameter int IDX_W       = 2,
    parameter int REVOKE_WAIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     cl_req,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] owner_o,
    output logic             xfer_o
);
    localparam int CNT_W = $clog2(REVOKE_WAIT + 1);

    arb_state_t       st_q, st_d;
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [N-1:0]     own_oh;
    logic             others;
    logic             hit;
    logic [IDX_W-1:0] win;

    assign own_oh = N'(1) << owner_q;
    assign others = |(cl_req & ~own_oh);

    sarb_rr_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req  (cl_req),
        .last (owner_q),
        .hit  (hit),
        .win  (win)
    );

    always_comb begin
        st_d    = st_q;
        owner_d = owner_q;
        cnt_d   = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (hit) begin
                    st_d    = ST_OWN;
                    owner_d = win;
                end
            end
            ST_OWN: begin
                if (!cl_req[owner_q]) begin
                    if (hit) owner_d = win;
                    else     st_d    = ST_IDLE;
                end else if (others) begin
                    if (cnt_q == CNT_W'(REVOKE_WAIT - 1)) st_d = ST_REVOKE;
                    else                                  cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REVOKE: begin
                if (!cl_req[owner_q]) begin
                    if (hit) begin
                        st_d    = ST_OWN;
                        owner_d = win;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            owner_q <= IDX_W'(N - 1);
            cnt_q   <= '0;
        end else begin
            st_q    <= st_d;
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        gnt_o   = (st_q == ST_OWN) ? own_oh : '0;
        owner_o = owner_q;
        xfer_o  = (st_q != ST_IDLE) && cl_req[owner_q];
    end

    // R6
    revoke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REVOKE && cl_req[owner_q]) |=> (st_q == ST_REVOKE));

    for (genvar i = 0; i < N; i++) begin : g_gnt_chk
        // R1
        grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gnt_o[i]) |-> $past(cl_req[i]));
        // R3
        grant_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gnt_o[i]) |-> (!$past(cl_req[i]) || st_q == ST_REVOKE));
    end
endmodule

// File: rtl/sarb_dpath.sv
module sarb_dpath #(
    parameter int N         = 3,
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int SRAM_PIPE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer,
    input  logic [IDX_W-1:0]    owner,
    input  logic [N-1:0]        cl_rnw,
    input  logic [N*ADDR_W-1:0] cl_addr,
    input  logic [N*DATA_W-1:0] cl_wdata,
    output logic [N*DATA_W-1:0] cl_rdata,
    output logic [N-1:0]        cl_rvalid,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_rnw,
    output logic [DATA_W-1:0]   sram_wdata,
    input  logic [DATA_W-1:0]   sram_rdata
);
    localparam int RD_LAT   = 6;
    localparam int WR_LAG   = 2;
    localparam int TAG_LEN  = RD_LAT - 1;
    localparam int D_STAGES = RD_LAT - 2 - SRAM_PIPE;
    localparam int W_STAGES = WR_LAG + 1;

    logic              in_v_q, in_rnw_q;
    logic [IDX_W-1:0]  in_id_q;
    logic [ADDR_W-1:0] in_addr_q;
    logic [DATA_W-1:0] in_wd_q;
    logic [TAG_LEN-1:0] tag_v_q;
    logic [IDX_W-1:0]  tag_id_q [TAG_LEN];
    logic [DATA_W-1:0] d_q [D_STAGES];
    logic [DATA_W-1:0] w_q [W_STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_v_q   <= 1'b0;
            in_rnw_q <= 1'b1;
            sram_rnw <= 1'b1;
            tag_v_q  <= '0;
        end else begin
            in_v_q   <= xfer;
            in_rnw_q <= cl_rnw[owner];
            sram_rnw <= !(in_v_q && !in_rnw_q);
            tag_v_q  <= {tag_v_q[TAG_LEN-2:0], in_v_q && in_rnw_q};
        end
        in_id_q    <= owner;
        in_addr_q  <= cl_addr[int'(owner)*ADDR_W +: ADDR_W];
        in_wd_q    <= cl_wdata[int'(owner)*DATA_W +: DATA_W];
        sram_addr  <= in_addr_q;
        tag_id_q[0] <= in_id_q;
        for (int s = 1; s < TAG_LEN; s++) tag_id_q[s] <= tag_id_q[s-1];
        w_q[0] <= in_wd_q;
        for (int s = 1; s < W_STAGES; s++) w_q[s] <= w_q[s-1];
        d_q[0] <= sram_rdata;
        for (int s = 1; s < D_STAGES; s++) d_q[s] <= d_q[s-1];
    end

    assign sram_wdata = w_q[W_STAGES-1];

    for (genvar k = 0; k < N; k++) begin : g_ret
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cl_rvalid[k]                 <= 1'b0;
                cl_rdata[k*DATA_W +: DATA_W] <= '0;
            end else begin
                cl_rvalid[k] <= tag_v_q[TAG_LEN-1] && (tag_id_q[TAG_LEN-1] == IDX_W'(k));
                if (tag_v_q[TAG_LEN-1] && (tag_id_q[TAG_LEN-1] == IDX_W'(k)))
                    cl_rdata[k*DATA_W +: DATA_W] <= d_q[D_STAGES-1];
            end
        end
    end

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v_q && in_rnw_q) |-> ##6 (|cl_rvalid));

    // R9
    idle_rnw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> ##1 sram_rnw);
endmodule

// File: rtl/sram_port_arbiter.sv
module sram_port_arbiter #(
    parameter int N_CLIENTS   = 3,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int REVOKE_WAIT = 16,
    parameter int SRAM_PIPE   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CLIENTS-1:0]        cl_req,
    output logic [N_CLIENTS-1:0]        cl_gnt,
    input  logic [N_CLIENTS-1:0]        cl_rnw,
    input  logic [N_CLIENTS*ADDR_W-1:0] cl_addr,
    input  logic [N_CLIENTS*DATA_W-1:0] cl_wdata,
    output logic [N_CLIENTS*DATA_W-1:0] cl_rdata,
    output logic [N_CLIENTS-1:0]        cl_rvalid,
    output logic [ADDR_W-1:0]           sram_addr,
    output logic                        sram_rnw,
    output logic [DATA_W-1:0]           sram_wdata,
    input  logic [DATA_W-1:0]           sram_rdata
);
    localparam int IDX_W = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;

    logic [IDX_W-1:0] owner;
    logic             xfer;

    sarb_ctrl #(.N(N_CLIENTS), .IDX_W(IDX_W), .REVOKE_WAIT(REVOKE_WAIT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cl_req  (cl_req),
        .gnt_o   (cl_gnt),
        .owner_o (owner),
        .xfer_o  (xfer)
    );

    sarb_dpath #(
        .N(N_CLIENTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SRAM_PIPE(SRAM_PIPE)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .owner      (owner),
        .cl_rnw     (cl_rnw),
        .cl_addr    (cl_addr),
        .cl_wdata   (cl_wdata),
        .cl_rdata   (cl_rdata),
        .cl_rvalid  (cl_rvalid),
        .sram_addr  (sram_addr),
        .sram_rnw   (sram_rnw),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata)
    );
endmodule

// File: tb/test_sram_port_arbiter.sv
`timescale 1ns/1ps
module test_sram_port_arbiter;
    localparam int N = 3;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int WT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, rnw = '1, gnt, rvalid;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wd = '0, rdata;
    logic [AW-1:0] s_addr;
    logic s_rnw;
    logic [DW-1:0] s_wd, s_rd;

    int checks = 0, fails = 0, cyc = 0, wdog = 0;
    bit finished = 0;
    logic [N-1:0] own = '0;
    logic [DW-1:0] mirror [64];
    logic [DW-1:0] last_rd [N];
    bit pv [16]; bit prnw [16]; logic [AW-1:0] paddr [16];
    bit wv [16]; logic [DW-1:0] wdx [16];
    logic [N-1:0] rv [16]; logic [DW-1:0] rdx [16];

    always #10 clk = ~clk;

    sram_port_arbiter #(.N_CLIENTS(N), .ADDR_W(AW), .DATA_W(DW),
                        .REVOKE_WAIT(WT), .SRAM_PIPE(2)) i_sram_port_arbiter (
        .clk(clk), .rst_n(rst_n), .cl_req(req), .cl_gnt(gnt), .cl_rnw(rnw),
        .cl_addr(addr), .cl_wdata(wd), .cl_rdata(rdata), .cl_rvalid(rvalid),
        .sram_addr(s_addr), .sram_rnw(s_rnw), .sram_wdata(s_wd), .sram_rdata(s_rd));

    // fixed-latency device stand-in: address sampled one edge after pins,
    // data out two edges after that, write data two edges behind address
    logic [DW-1:0] mem [64];
    logic [DW-1:0] q1, wq;
    logic w2, w3, w4;
    logic [AW-1:0] wa2, wa3, wa4;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= DW'(i * 37 + 5);
            w2 <= 0; w3 <= 0; w4 <= 0;
        end else begin
            q1 <= mem[s_addr]; s_rd <= q1;
            w2 <= !s_rnw; wa2 <= s_addr;
            w3 <= w2; wa3 <= wa2;
            w4 <= w3; wa4 <= wa3; wq <= s_wd;
            if (w4) mem[wa4] <= wq;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // recorder: commands accepted at the coming edge e = cyc+1
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; own = '0;
            for (int s = 0; s < 16; s++) begin pv[s] = 0; wv[s] = 0; rv[s] = '0; end
        end else begin
            for (int c = 0; c < N; c++) begin
                if (req[c] && own[c]) begin
                    automatic int e = cyc + 1;
                    automatic logic [AW-1:0] a = addr[c*AW +: AW];
                    pv[(e+1)%16] = 1; prnw[(e+1)%16] = rnw[c]; paddr[(e+1)%16] = a;
                    if (rnw[c]) begin
                        rv[(e+6)%16] = N'(1) << c; rdx[(e+6)%16] = mirror[a];
                    end else begin
                        wv[(e+3)%16] = 1; wdx[(e+3)%16] = wd[c*DW +: DW];
                        mirror[a] = wd[c*DW +: DW];
                    end
                end
                if (!req[c]) own[c] = 0;
            end
            cyc = cyc + 1;
        end
    end

    // per-cycle pin and return checker
    always @(negedge clk) begin
        if (rst_n) begin
            automatic int s = cyc % 16;
            chk(s_rnw == (pv[s] ? prnw[s] : 1'b1), "R9", 64'(s_rnw), 64'(pv[s] ? prnw[s] : 1'b1));
            if (pv[s]) chk(s_addr == paddr[s], "R10", 64'(s_addr), 64'(paddr[s]));
            if (wv[s]) chk(s_wd == wdx[s], "R8", 64'(s_wd), 64'(wdx[s]));
            chk(rvalid == rv[s], "R7", 64'(rvalid), 64'(rv[s]));
            for (int c = 0; c < N; c++) begin
                if (rv[s][c]) last_rd[c] = rdx[s];
                chk(rdata[c*DW +: DW] == last_rd[c], "R7", 64'(rdata[c*DW +: DW]), 64'(last_rd[c]));
            end
            pv[s] = 0; wv[s] = 0; rv[s] = '0;
            for (int c = 0; c < N; c++) if (gnt[c]) own[c] = 1;
        end
    end

    always @(posedge clk) begin
        wdog++;
        if (wdog > 5000 && !finished) begin
            fails++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected=under 5000", wdog);
            summary();
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic gchk(input logic [N-1:0] exp, input string rq);
        chk(gnt == exp, rq, 64'(gnt), 64'(exp));
    endtask

    task automatic set_cl(input int c, input bit r, input int a, input int d);
        rnw[c] = r; addr[c*AW +: AW] = AW'(a); wd[c*DW +: DW] = DW'(d);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mirror[i] = DW'(i * 37 + 5);
        for (int c = 0; c < N; c++) last_rd[c] = '0;
        for (int c = 0; c < N; c++) set_cl(c, 1, 10 + c * 5, 16'hA000 + c);
        repeat (3) step();
        gchk('0, "R9");
        chk(rvalid == '0, "R9", 64'(rvalid), 0);
        chk(s_rnw == 1'b1, "R9", 64'(s_rnw), 1);
        rst_n = 1'b1;
        step();

        // round-robin and handover (R1 R3 R4)
        req = 3'b111; step(); gchk(3'b001, "R4");
        req = 3'b110; step(); gchk(3'b010, "R3");
        req = 3'b100; step(); gchk(3'b100, "R3");
        req = 3'b000; step(); gchk(3'b000, "R3");
        req = 3'b011; step(); gchk(3'b001, "R4");
        req = 3'b010; step(); gchk(3'b010, "R3");
        req = 3'b101; step(); gchk(3'b100, "R4");
        req = 3'b001; step(); gchk(3'b001, "R3");
        req = 3'b000; step(); gchk(3'b000, "R3");

        // sticky grant then withdrawal (R1 R2 R5 R6 R10)
        req = 3'b001; step(); gchk(3'b001, "R1");
        for (int k = 0; k < 6; k++) begin step(); gchk(3'b001, "R2"); end
        set_cl(1, 0, 50, 16'hBEEF);
        req = 3'b011;
        for (int k = 1; k <= WT; k++) begin
            set_cl(0, 1, 20 + k, 0);
            step(); gchk(k < WT ? 3'b001 : 3'b000, "R5");
        end
        for (int k = 0; k < 3; k++) begin
            set_cl(0, 1, 30 + k, 0);
            step(); gchk(3'b000, "R6");
        end
        req = 3'b010; step(); gchk(3'b010, "R6");
        set_cl(1, 1, 11, 0);
        req = 3'b000; step(); gchk(3'b000, "R3");

        // waiting interrupted restarts the count (R5)
        req = 3'b001; step(); gchk(3'b001, "R1");
        req = 3'b011;
        for (int k = 1; k < WT; k++) begin step(); gchk(3'b001, "R5"); end
        req = 3'b001; step(); gchk(3'b001, "R5");
        req = 3'b011;
        for (int k = 1; k <= WT; k++) begin step(); gchk(k < WT ? 3'b001 : 3'b000, "R5"); end
        req = 3'b010; step(); gchk(3'b010, "R6");
        req = 3'b000; step(); gchk(3'b000, "R3");

        // per-client write then read sweep with conflicting non-owners (R7 R8 R10)
        for (int c = 0; c < N; c++) begin
            req = N'(1) << c; step(); gchk(N'(1) << c, "R1");
            for (int a = 0; a < 8; a++) begin
                for (int o = 0; o < N; o++) if (o != c) set_cl(o, 0, 63 - a, 16'h5555);
                set_cl(c, 0, c * 8 + a, (c * 8 + a) * 251 + 17);
                step();
            end
            for (int a = 0; a < 8; a++) begin
                set_cl(c, 1, c * 8 + a, 0);
                step();
            end
            for (int o = 0; o < N; o++) set_cl(o, 1, 40, 0);
            req = '0; step(); gchk('0, "R3");
        end
        repeat (10) step();
        summary();
    end
endmodule